// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

This block is one bank of up to 32 general-purpose pins on a simple synchronous register bus. The pins are split into four 8-bit ports, A to D. Software sets each pin as an input or an output, writes an output latch, and reads back pin levels. It also picks, for each pin, which edges of the input set a pending bit. The pending bits of the whole bank are combined onto one interrupt line, and software clears them one bit at a time or one port byte at a time.

Pin inputs pass through a two-flop synchronizer. An edge is found by comparing the synchronized level with the level one cycle earlier. The bank size `NPINS` can be set from 1 to 32. Register bits that belong to pins that are not implemented read as zero and never become pending.

Registers are word-addressed through `busAddr` (word index = byte offset / 4): 0 pin-select, 1 spare, 2 direction, 3 data, 4 pending status, 5 edge field for ports A/B, 6 edge field for ports C/D, 7 just past the window.

Top module: `gpio_bank`

## Requirements
- R1: After reset, `pinOe` and `pinOut` are all zero, `irq` is low, and the direction, status and both edge-field registers read zero.
- R2: A direction bit of 1 drives the pin as an output (`pinOe` high). In every one-bit-per-pin register, pin p sits at word bit 8*(3-p/8)+p%8, so port A occupies bits 31:24 and port D occupies bits 7:0.
- R3: A write to data changes only the output latch (`pinOut`). A read of data returns the latch for output pins and the synchronized level for input pins. The synchronized level is visible two clocks after the pin changes.
- R4: Byte enable `busBe[i]` gates write byte `busWdata[8i+7:8i]`. Bytes that are not enabled keep their value in every writable register.
- R5: The edge field gives each pin 2 bits, coded 0 none, 1 falling, 2 rising, 3 both. Word 5 holds port A in bits 31:16 and port B in bits 15:0. Word 6 holds port C in 31:16 and port D in 15:0. Pin n of a port uses bits 2n+1:2n of its half.
- R6: A pending bit is set only when its pin shows an edge that its code selects. It appears in the status register and raises `irq` on the third rising clock after the pin changes. `irq` is the OR of all pending bits.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it alone. A single byte-enabled write clears bits of one port only.
- R8: If a new edge and a clear of the same bit land in the same cycle, the bit stays set.
- R9: Bits of pins numbered NPINS and above read zero in every register and never become pending.
- R10: The pin-select word (0) reads zero and writes to it have no effect. Words 1 and 7 also read zero.
- R11: Read data is registered. It appears one cycle after the read request, and `busRdata` is zero in every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Bus request this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word index within the bank |
| busBe | input | 4 | Byte enables for writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| pinIn | input | NPINS | Pin input levels (asynchronous) |
| pinOut | output | NPINS | Output latch per pin |
| pinOe | output | NPINS | Output enable per pin |
| irq | output | 1 | OR of all pending bits |

## Verification
The hardest case to reach is a status clear that lands on the same clock edge as a new edge of the same pin. The bench counts the three synchronizer and edge-detect stages from the pin toggle, and starts the write-one-to-clear two cycles after the toggle so that both commit on the third edge. The other difficult cases are byte-wise partial clears and the zero bits of port D with a 24-pin bank. The bench reaches these by arming every pin for both edges, toggling all of the pins at once, and then clearing one port lane at a time.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    REG_PSEL  = 3'd0,
    REG_SPARE = 3'd1,
    REG_DIR   = 3'd2,
    REG_DATA  = 3'd3,
    REG_STAT  = 3'd4,
    REG_EDGAB = 3'd5,
    REG_EDGCD = 3'd6,
    REG_PAST  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrData;
    logic    wrStat;
    logic    wrEdgAB;
    logic    wrEdgCD;
    logic    rdEn;
    regSel_e rdSel;
    logic [3:0] be;
  } strobe_t;

  // word bit holding pin p: port A in the top byte
  function automatic int pinBit(int p);
    return (3 - p / 8) * 8 + p % 8;
  endfunction

  function automatic logic [31:0] laneMask(logic [3:0] be);
    logic [31:0] m;
    for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{be[l]}};
    return m;
  endfunction

  function automatic logic [31:0] pinImpl(int n);
    logic [31:0] m;
    m = '0;
    for (int p = 0; p < 32; p++) if (p < n) m[pinBit(p)] = 1'b1;
    return m;
  endfunction

  // implemented bits of an edge-field word; firstPort is 0 (A/B) or 2 (C/D)
  function automatic logic [31:0] edgeImpl(int n, int firstPort);
    logic [31:0] m;
    for (int b = 0; b < 32; b++)
      m[b] = ((firstPort + (b < 16 ? 1 : 0)) * 8 + (b % 16) / 2) < n;
    return m;
  endfunction

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic       busSel,
  input  logic       busWe,
  input  logic [2:0] busAddr,
  input  logic [3:0] busBe,
  output strobe_t    st
);

  regSel_e sel;

  always_comb begin
    sel      = regSel_e'(busAddr);
    st       = '0;
    st.be    = busBe;
    st.rdSel = sel;
    st.rdEn  = busSel && !busWe;
    if (busSel && busWe) begin
      unique case (sel)
        REG_DIR:   st.wrDir   = 1'b1;
        REG_DATA:  st.wrData  = 1'b1;
        REG_STAT:  st.wrStat  = 1'b1;
        REG_EDGAB: st.wrEdgAB = 1'b1;
        REG_EDGCD: st.wrEdgCD = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic             irq
);

  localparam logic [31:0] PIN_IMPL = pinImpl(NPINS);
  localparam logic [31:0] EAB_IMPL = edgeImpl(NPINS, 0);
  localparam logic [31:0] ECD_IMPL = edgeImpl(NPINS, 2);

  logic [31:0] dirW, outW, statW, edgAB, edgCD;
  logic [31:0] inW, sync1, sync2, prevW;
  logic [31:0] wrMask, rise, fall, hit, clrW, rdVal;
  logic [1:0]  code [32];

  always_comb begin
    inW = '0;
    for (int p = 0; p < NPINS; p++) inW[pinBit(p)] = pinIn[p];
  end

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      pinOut[p] = outW[pinBit(p)];
      pinOe[p]  = dirW[pinBit(p)];
    end
  end

  assign wrMask = laneMask(st.be);

  // per word bit: which edges arm it
  always_comb begin
    for (int b = 0; b < 32; b++) begin
      int port, off;
      port = 3 - b / 8;
      off  = ((port % 2 == 0) ? 16 : 0) + 2 * (b % 8);
      code[b] = (port < 2) ? edgAB[off +: 2] : edgCD[off +: 2];
    end
  end

  assign rise = sync2 & ~prevW;
  assign fall = ~sync2 & prevW;

  always_comb begin
    for (int b = 0; b < 32; b++)
      hit[b] = (rise[b] & code[b][1]) | (fall[b] & code[b][0]);
  end

  assign clrW = st.wrStat ? (busWdata & wrMask) : '0;

  always_comb begin
    unique case (st.rdSel)
      REG_DIR:   rdVal = dirW;
      REG_DATA:  rdVal = (dirW & outW) | (~dirW & sync2);
      REG_STAT:  rdVal = statW;
      REG_EDGAB: rdVal = edgAB;
      REG_EDGCD: rdVal = edgCD;
      default:   rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirW     <= '0;
      outW     <= '0;
      statW    <= '0;
      edgAB    <= '0;
      edgCD    <= '0;
      sync1    <= '0;
      sync2    <= '0;
      prevW    <= '0;
      busRdata <= '0;
    end else begin
      sync1 <= inW;
      sync2 <= sync1;
      prevW <= sync2;
      if (st.wrDir)   dirW  <= ((dirW  & ~wrMask) | (busWdata & wrMask)) & PIN_IMPL;
      if (st.wrData)  outW  <= ((outW  & ~wrMask) | (busWdata & wrMask)) & PIN_IMPL;
      if (st.wrEdgAB) edgAB <= ((edgAB & ~wrMask) | (busWdata & wrMask)) & EAB_IMPL;
      if (st.wrEdgCD) edgCD <= ((edgCD & ~wrMask) | (busWdata & wrMask)) & ECD_IMPL;
      statW    <= ((statW & ~clrW) | hit) & PIN_IMPL;
      busRdata <= st.rdEn ? rdVal : '0;
    end
  end

  assign irq = |statW;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWe,
  input  logic [2:0]       busAddr,
  input  logic [3:0]       busBe,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic             irq
);

  strobe_t st;

  gpio_bank_ctrl uCtrl (
    .busSel (busSel),
    .busWe  (busWe),
    .busAddr(busAddr),
    .busBe  (busBe),
    .st     (st)
  );

  gpio_bank_dp #(.NPINS(NPINS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irq     (irq)
  );

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWe,
  input logic [2:0]       busAddr,
  input logic [31:0]      busRdata,
  input logic [NPINS-1:0] pinOut,
  input logic [NPINS-1:0] pinOe,
  input logic             irq
);

  // R2 / R10: enables move only after a direction write
  a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWe && busAddr == 3'd2) |=> $stable(pinOe));

  // R3: latch moves only after a data write
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWe && busAddr == 3'd3) |=> $stable(pinOut));

  // R7: pending line drops only after a status write
  a_r7_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(busSel && busWe && busAddr == 3'd4));

  // R10: pin-select word reads zero
  a_r10_psel_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && busAddr == 3'd0) |=> busRdata == 32'h0);

  // R11: idle read bus is zero
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWe) |=> busRdata == 32'h0);

endmodule

bind gpio_bank gpio_bank_checker #(.NPINS(NPINS)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWe   (busWe),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .irq     (irq)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

  localparam int NP = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0, busWe = 1'b0;
  logic [2:0]    busAddr = '0;
  logic [3:0]    busBe = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NP-1:0] pinIn = '0;
  logic [NP-1:0] pinOut, pinOe;
  logic          irq;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_bank #(.NPINS(NP)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  // {pin[4:0], code[1:0], rising, expectPending}
  localparam logic [8:0] VEC [0:7] = '{
    {5'd0,  2'd2, 1'b1, 1'b1},
    {5'd0,  2'd2, 1'b0, 1'b0},
    {5'd9,  2'd1, 1'b0, 1'b1},
    {5'd9,  2'd1, 1'b1, 1'b0},
    {5'd17, 2'd3, 1'b1, 1'b1},
    {5'd23, 2'd3, 1'b0, 1'b1},
    {5'd5,  2'd0, 1'b1, 1'b0},
    {5'd12, 2'd3, 1'b0, 1'b1}
  };

  function automatic int wbit(int p);
    return (3 - p / 8) * 8 + p % 8;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] be, logic [31:0] d);
    busSel = 1; busWe = 1; busAddr = a; busBe = be; busWdata = d;
    @(negedge clk);
    busSel = 0; busWe = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    busSel = 1; busWe = 0; busAddr = a;
    @(negedge clk);
    busSel = 0;
    d = busRdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(3);
    rstN = 1;
    idle(2);

    // R1 reset state
    check("R1 oe", 32'(pinOe), 0);
    check("R1 out", 32'(pinOut), 0);
    check("R1 irq", 32'(irq), 0);
    rd(3'd2, r); check("R1 dir", r, 0);
    rd(3'd4, r); check("R1 stat", r, 0);
    rd(3'd5, r); check("R1 edgAB", r, 0);
    rd(3'd6, r); check("R1 edgCD", r, 0);
    idle(1);
    check("R11 idle bus zero", busRdata, 0);

    // R10 pin-select and spare words
    wr(3'd0, 4'hF, 32'hFFFF_FFFF);
    check("R10 psel no effect", 32'(pinOe), 0);
    rd(3'd0, r); check("R10 psel read", r, 0);
    rd(3'd1, r); check("R10 spare read", r, 0);
    rd(3'd7, r); check("R10 past window", r, 0);

    // R2 / R9 direction and bit layout
    wr(3'd2, 4'hF, 32'hFF00_00FF);
    check("R2 oe port A", 32'(pinOe), 32'h0000FF);
    rd(3'd2, r); check("R9 dir port D zero", r, 32'hFF00_0000);

    // R4 byte enables
    wr(3'd2, 4'b0100, 32'h00FF_FF00);
    rd(3'd2, r); check("R4 dir lane B only", r, 32'hFFFF_0000);
    check("R4 oe", 32'(pinOe), 32'h00FFFF);

    // R3 data latch and mixed readback
    pinIn = 24'h5A_FFFF;
    wr(3'd3, 4'hF, 32'hA53C_0000);
    check("R3 pinOut", 32'(pinOut), 32'h003CA5);
    idle(2);
    rd(3'd3, r); check("R3 data read", r, 32'hA53C_5A00);

    wr(3'd2, 4'hF, 32'h0);
    pinIn = '0;
    idle(4);
    rd(3'd4, r); check("R6 no arm no pending", r, 0);

    // table of edge cases: R5 / R6
    foreach (VEC[i]) begin
      int p, off;
      logic [2:0] ea;
      p   = int'(VEC[i][8:4]);
      off = (((p / 8) % 2 == 0) ? 16 : 0) + 2 * (p % 8);
      ea  = (p / 8 < 2) ? 3'd5 : 3'd6;
      wr(3'd5, 4'hF, 0);
      wr(3'd6, 4'hF, 0);
      pinIn[p] = !VEC[i][1];
      idle(4);
      wr(3'd4, 4'hF, 32'hFFFF_FFFF);
      wr(ea, 4'hF, 32'(VEC[i][3:2]) << off);
      pinIn[p] = VEC[i][1];
      idle(2);
      check("R6 irq latency", 32'(irq), 0);
      idle(1);
      check("R6 irq after edge", 32'(irq), 32'(VEC[i][0]));
      rd(3'd4, r);
      check("R5 pending bit", r, 32'(VEC[i][0]) << wbit(p));
    end
    wr(3'd5, 4'hF, 0);
    wr(3'd6, 4'hF, 0);
    pinIn = '0;
    idle(4);
    wr(3'd4, 4'hF, 32'hFFFF_FFFF);

    // R7 / R9 whole bank armed
    wr(3'd5, 4'hF, 32'hFFFF_FFFF);
    wr(3'd6, 4'hF, 32'hFFFF_FFFF);
    rd(3'd6, r); check("R9 edge field port D zero", r, 32'hFFFF_0000);
    pinIn = '1;
    idle(4);
    rd(3'd4, r); check("R9 pending no port D", r, 32'hFFFF_FF00);
    wr(3'd4, 4'b0100, 32'hFFFF_FFFF);
    rd(3'd4, r); check("R7 clear lane B", r, 32'hFF00_FF00);
    wr(3'd4, 4'hF, 32'h0F00_0000);
    rd(3'd4, r); check("R7 zero keeps", r, 32'hF000_FF00);
    wr(3'd4, 4'hF, 32'hFFFF_FFFF);
    check("R7 all clear irq", 32'(irq), 0);

    // R8 edge and clear in the same cycle
    pinIn[20] = 1'b0;
    idle(2);
    wr(3'd4, 4'hF, 32'hFFFF_FFFF);
    check("R8 irq held", 32'(irq), 1);
    rd(3'd4, r); check("R8 edge wins", r, 32'h1 << wbit(20));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule